// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

A 32-bit processor core that retires one instruction per clock cycle. It runs a small subset of a classic three-operand load/store instruction set: word load, word store, register add, subtract, and, or, signed set-less-than, branch-if-equal and an absolute jump. The core holds the program counter, a 32-entry register file, the ALU, the immediate sign extender, the opcode decoder, the ALU operation decoder, the operand and write-back multiplexers, and two small internal word memories, one for instructions and one for data.

The core runs while `run_i` is high. While it is low, the program counter and all architectural state hold, and a word-wide load port may fill either memory. Two debug read ports expose any register and any data-memory word at all times. Memories are indexed by address bits `[MEM_AW+1:2]`, so addresses outside the arrays alias into them.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals `START_ADDR` and every register reads zero; memory contents are left untouched by reset.
- R2: On each rising edge with `run_i` high the PC advances by 4 unless a taken branch or a jump redirects it; the fetched word is instruction-memory entry `pc[MEM_AW+1:2]`. With `run_i` low the PC holds and neither registers nor data memory change.
- R3: When `run_i` is low, `ld_we_i` writes `ld_data_i` into entry `ld_addr_i` of instruction memory (`ld_sel_i`=0) or data memory (`ld_sel_i`=1) at the rising edge; with `run_i` high the load port has no effect on either memory.
- R4: Opcode field bits [31:26] = 0x00 selects the register form, with rs in [25:21], rt in [20:16], rd in [15:11] and funct in [5:0]; funct 0x20 writes rs+rt, 0x22 rs-rt, 0x24 rs AND rt, 0x25 rs OR rt, 0x2a writes 1 if rs < rt as signed values and 0 otherwise, into rd.
- R5: Opcode 0x23 writes rt with data-memory word at (rs + sign-extended bits [15:0]); an immediate of 0xfff4 adds -12.
- R6: Opcode 0x2b writes register rt into data memory at (rs + sign-extended bits [15:0]).
- R7: Opcode 0x04 compares rs and rt; when equal the next PC is the branch's own address plus the sign-extended immediate shifted left by 2, otherwise PC+4.
- R8: Opcode 0x02 loads the PC with {current PC bits [31:28], instruction bits [25:0], 2'b00}.
- R9: Register 0 always reads zero; writes to it are discarded.
- R10: Any other opcode writes no register and no memory and advances the PC by 4.
- R11: `dbg_reg_data_o` and `dbg_mem_data_o` follow their address inputs combinationally, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Execute one instruction per cycle when high |
| ld_we_i | input | 1 | Load port write strobe (only while not running) |
| ld_sel_i | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr_i | input | MEM_AW | Load word index |
| ld_data_i | input | 32 | Load word |
| dbg_reg_addr_i | input | 5 | Debug register index |
| dbg_reg_data_o | output | 32 | Debug register value |
| dbg_mem_addr_i | input | MEM_AW | Debug data-memory word index |
| dbg_mem_data_o | output | 32 | Debug data-memory word |
| pc_o | output | 32 | Current program counter |

## Verification
Every architectural effect of an instruction (register write, data-memory write, new PC) becomes visible right after the rising edge that retires it, so the bench steps its own instruction-level model once per rising edge and compares `pc_o` at the following falling edge. Load-port writes land at the same edge and are mirrored in the model only when `run_i` is low. Debug reads need no edge, so register and memory contents are compared after a short settling delay while the core is stopped; effects of ignored loads are brought out by re-executing from reset.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int unsigned XLEN = 32;
  localparam int unsigned RAW  = 5;

  typedef enum logic [5:0] {
    OPC_REG = 6'h00,
    OPC_JMP = 6'h02,
    OPC_BEQ = 6'h04,
    OPC_LDW = 6'h23,
    OPC_STW = 6'h2b
  } opc_e;

  typedef enum logic [5:0] {
    FN_ADD = 6'h20,
    FN_SUB = 6'h22,
    FN_AND = 6'h24,
    FN_OR  = 6'h25,
    FN_SLT = 6'h2a
  } fn_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  // ALU operation class issued by the opcode decoder
  typedef enum logic [1:0] {
    CLS_ADDR = 2'd0,
    CLS_CMP  = 2'd1,
    CLS_FN   = 2'd2
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_we;
    logic     mem_rd;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_core_pkg::*;
(
  input  logic [5:0] opc_i,
  input  logic [5:0] fn_i,
  output ctl_t       ctl_o,
  output alu_op_e    alu_op_o
);

  always_comb begin
    ctl_o     = '0;
    ctl_o.cls = CLS_ADDR;
    case (opc_i)
      OPC_REG: begin
        ctl_o.dst_rd = 1'b1;
        ctl_o.reg_we = 1'b1;
        ctl_o.cls    = CLS_FN;
      end
      OPC_LDW: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.wb_mem  = 1'b1;
        ctl_o.reg_we  = 1'b1;
        ctl_o.mem_rd  = 1'b1;
      end
      OPC_STW: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl_o.branch = 1'b1;
        ctl_o.cls    = CLS_CMP;
      end
      OPC_JMP: ctl_o.jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    alu_op_o = ALU_ADD;
    case (ctl_o.cls)
      CLS_CMP: alu_op_o = ALU_SUB;
      CLS_FN: begin
        case (fn_i)
          FN_SUB:  alu_op_o = ALU_SUB;
          FN_AND:  alu_op_o = ALU_AND;
          FN_OR:   alu_op_o = ALU_OR;
          FN_SLT:  alu_op_o = ALU_SLT;
          default: alu_op_o = ALU_ADD;
        endcase
      end
      default: alu_op_o = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);

  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = ($signed(a_i) < $signed(b_i)) ? W'(1) : '0;
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [$clog2(NREG)-1:0] ra_a_i,
  output logic [W-1:0]            rd_a_o,
  input  logic [$clog2(NREG)-1:0] ra_b_i,
  output logic [W-1:0]            rd_b_o,
  input  logic [$clog2(NREG)-1:0] ra_dbg_i,
  output logic [W-1:0]            rd_dbg_o
);

  logic [W-1:0] regs_q [NREG];

  // entry 0 is cleared at reset and never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rd_a_o   = regs_q[ra_a_i];
  assign rd_b_o   = regs_q[ra_b_i];
  assign rd_dbg_o = regs_q[ra_dbg_i];

endmodule

// File: rtl/sc_wmem.sv
module sc_wmem #(
  parameter int unsigned AW  = 6,
  parameter int unsigned W   = 32,
  parameter int unsigned NRD = 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [W-1:0]  rdata_o [NRD]
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter logic [31:0] START_ADDR = 32'h0040_0000,
  parameter int unsigned MEM_AW     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ld_we_i,
  input  logic              ld_sel_i,
  input  logic [MEM_AW-1:0] ld_addr_i,
  input  logic [31:0]       ld_data_i,
  input  logic [4:0]        dbg_reg_addr_i,
  output logic [31:0]       dbg_reg_data_o,
  input  logic [MEM_AW-1:0] dbg_mem_addr_i,
  output logic [31:0]       dbg_mem_data_o,
  output logic [31:0]       pc_o
);

  localparam int unsigned IX_HI = MEM_AW + 1;

  logic [XLEN-1:0] pc_q, pc_nxt, pc_seq, pc_br, pc_jmp;
  logic [XLEN-1:0] instr, sext, rs_v, rt_v, alu_b, alu_y, wb_data, mem_rdata;
  logic [RAW-1:0]  wreg;
  logic            alu_zero, br_taken, rf_we, dmem_we, ld_ok;
  ctl_t            ctl;
  alu_op_e         alu_op;

  // instruction memory: written only through the load port
  logic [MEM_AW-1:0] im_ra [1];
  logic [XLEN-1:0]   im_rd [1];

  assign ld_ok    = ld_we_i & ~run_i;
  assign im_ra[0] = pc_q[IX_HI:2];
  assign instr    = im_rd[0];

  sc_wmem #(.AW(MEM_AW), .W(XLEN), .NRD(1)) u_imem (
    .clk_i   (clk_i),
    .we_i    (ld_ok & ~ld_sel_i),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (im_ra),
    .rdata_o (im_rd)
  );

  sc_ctrl u_ctrl (
    .opc_i    (instr[31:26]),
    .fn_i     (instr[5:0]),
    .ctl_o    (ctl),
    .alu_op_o (alu_op)
  );

  assign wreg  = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we = run_i & ctl.reg_we;

  sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (wreg),
    .wdata_i  (wb_data),
    .ra_a_i   (instr[25:21]),
    .rd_a_o   (rs_v),
    .ra_b_i   (instr[20:16]),
    .rd_b_o   (rt_v),
    .ra_dbg_i (dbg_reg_addr_i),
    .rd_dbg_o (dbg_reg_data_o)
  );

  assign sext  = {{16{instr[15]}}, instr[15:0]};
  assign alu_b = ctl.src_imm ? sext : rt_v;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_v),
    .b_i    (alu_b),
    .op_i   (alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // data memory: store port has priority, load port only while stopped
  logic [MEM_AW-1:0] dm_ra [2];
  logic [XLEN-1:0]   dm_rd [2];
  logic [MEM_AW-1:0] dm_waddr;
  logic [XLEN-1:0]   dm_wdata;

  assign dmem_we  = run_i & ctl.mem_we;
  assign dm_waddr = dmem_we ? alu_y[IX_HI:2] : ld_addr_i;
  assign dm_wdata = dmem_we ? rt_v : ld_data_i;
  assign dm_ra[0] = alu_y[IX_HI:2];
  assign dm_ra[1] = dbg_mem_addr_i;

  sc_wmem #(.AW(MEM_AW), .W(XLEN), .NRD(2)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dmem_we | (ld_ok & ld_sel_i)),
    .waddr_i (dm_waddr),
    .wdata_i (dm_wdata),
    .raddr_i (dm_ra),
    .rdata_o (dm_rd)
  );

  assign mem_rdata      = ctl.mem_rd ? dm_rd[0] : '0;
  assign dbg_mem_data_o = dm_rd[1];
  assign wb_data        = ctl.wb_mem ? mem_rdata : alu_y;

  // next PC: branch offset is relative to the branch itself
  assign br_taken = ctl.branch & alu_zero;
  assign pc_seq   = pc_q + 32'd4;
  assign pc_br    = pc_q + {sext[29:0], 2'b00};
  assign pc_jmp   = {pc_q[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.jump)      pc_nxt = pc_jmp;
    else if (br_taken) pc_nxt = pc_br;
    else               pc_nxt = pc_seq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= START_ADDR;
    else if (run_i) pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_i,
  input logic [31:0] pc_o,
  input logic [4:0]  dbg_reg_addr_i,
  input logic [31:0] dbg_reg_data_o,
  input logic        taken_i,
  input logic        jump_i,
  input logic        branch_i,
  input logic        mem_rd_i,
  input logic        mem_we_i,
  input logic        rf_we_i,
  input logic        dm_we_i,
  input logic [31:0] br_off_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_PC: assert (pc_o == START_ADDR); // R1
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_o)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!rf_we_i && !dm_we_i)); // R2

  AST_PC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !taken_i && !jump_i) |=> pc_o == $past(pc_o) + 32'd4); // R2

  AST_BR_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && taken_i) |=> pc_o == $past(pc_o) + {$past(br_off_i[29:0]), 2'b00}); // R7

  AST_JMP_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && jump_i) |=> pc_o[31:28] == $past(pc_o[31:28])); // R8

  AST_R0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_reg_addr_i == 5'd0) |-> (dbg_reg_data_o == 32'd0)); // R9

  AST_CTL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_i, mem_we_i, branch_i, jump_i})); // R4

endmodule

bind sc_core sc_core_chk #(.START_ADDR(START_ADDR)) u_sc_core_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .run_i          (run_i),
  .pc_o           (pc_o),
  .dbg_reg_addr_i (dbg_reg_addr_i),
  .dbg_reg_data_o (dbg_reg_data_o),
  .taken_i        (br_taken),
  .jump_i         (ctl.jump),
  .branch_i       (ctl.branch),
  .mem_rd_i       (ctl.mem_rd),
  .mem_we_i       (ctl.mem_we),
  .rf_we_i        (rf_we),
  .dm_we_i        (dmem_we),
  .br_off_i       (sext)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;

  localparam int          MEM_AW = 6;
  localparam int          DEPTH  = 1 << MEM_AW;
  localparam logic [31:0] START  = 32'h0040_0000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              run_i = 1'b0;
  logic              ld_we_i = 1'b0;
  logic              ld_sel_i = 1'b0;
  logic [MEM_AW-1:0] ld_addr_i = '0;
  logic [31:0]       ld_data_i = '0;
  logic [4:0]        dbg_reg_addr_i = '0;
  logic [31:0]       dbg_reg_data_o;
  logic [MEM_AW-1:0] dbg_mem_addr_i = '0;
  logic [31:0]       dbg_mem_data_o;
  logic [31:0]       pc_o;

  sc_core #(.START_ADDR(START), .MEM_AW(MEM_AW)) u_sc_core (
    .clk_i, .rst_ni, .run_i, .ld_we_i, .ld_sel_i, .ld_addr_i, .ld_data_i,
    .dbg_reg_addr_i, .dbg_reg_data_o, .dbg_mem_addr_i, .dbg_mem_data_o, .pc_o
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_imem [DEPTH];
  logic [31:0] m_dmem [DEPTH];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [31:0] tgt);
    return {6'h02, tgt[27:2]};
  endfunction

  function automatic logic [31:0] alu_ref(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2a:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  // instruction-level reference, one step per rising edge
  task automatic model_step();
    logic [31:0] ins, a, b, sx, npc, ad;
    int rs, rt, rd;
    if (!run_i) begin
      if (ld_we_i) begin
        if (ld_sel_i) m_dmem[ld_addr_i] = ld_data_i;
        else          m_imem[ld_addr_i] = ld_data_i;
      end
      return;
    end
    ins = m_imem[m_pc[MEM_AW+1:2]];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = m_reg[rs]; b = m_reg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = m_pc + 32'd4;
    ad = a + sx;
    case (ins[31:26])
      6'h00: if (rd != 0) m_reg[rd] = alu_ref(ins[5:0], a, b);
      6'h23: if (rt != 0) m_reg[rt] = m_dmem[ad[MEM_AW+1:2]];
      6'h2b: m_dmem[ad[MEM_AW+1:2]] = b;
      6'h04: if (a == b) npc = m_pc + {sx[29:0], 2'b00};
      6'h02: npc = {m_pc[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    m_pc = npc;
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk("R2/R7/R8 pc", pc_o, m_pc);
  endtask

  task automatic load(input logic sel, input int addr, input logic [31:0] data);
    ld_we_i = 1'b1; ld_sel_i = sel; ld_addr_i = MEM_AW'(addr); ld_data_i = data;
    tick();
    ld_we_i = 1'b0;
  endtask

  task automatic assert_reset();
    rst_ni = 1'b0;
    run_i  = 1'b0;
    m_pc = START;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    @(negedge clk_i);
    chk("R1 reset pc", pc_o, START);
  endtask

  task automatic check_state();
    for (int i = 0; i < 32; i++) begin
      dbg_reg_addr_i = 5'(i);
      #1;
      chk("R4/R5/R9/R11 reg", dbg_reg_data_o, m_reg[i]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      dbg_mem_addr_i = MEM_AW'(i);
      #1;
      chk("R6/R11 dmem", dbg_mem_data_o, m_dmem[i]);
    end
  endtask

  function automatic logic [31:0] rnd_ins();
    int k = int'($urandom % 10);
    int rs = int'($urandom % 16);
    int rt = int'($urandom % 16);
    int rd = int'($urandom % 16);
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2a};
    case (k)
      0, 1: return enc_i(6'h23, rs, rt, 16'(($urandom % 64) * 4));
      2:    return enc_i(6'h2b, rs, rt, 16'(($urandom % 64) * 4));
      7, 8: return enc_i(6'h04, rs % 4, rt % 4, 16'(int'($urandom % 17) - 8));
      9:    return enc_j(START + 32'(($urandom % 64) * 4));
      default: return enc_r(rs, rt, rd, fns[$urandom % 5]);
    endcase
  endfunction

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    void'($urandom(32'd4711));
    #2;
    // ---------------- directed program ----------------
    assert_reset();
    for (int i = 0; i < DEPTH; i++) load(1'b1, i, 32'h1000_0000 + 32'(i));
    load(1'b1, 1, 32'h5);
    load(1'b1, 2, 32'h10);
    for (int i = 0; i < DEPTH; i++) load(1'b0, i, 32'h0);
    load(1'b0, 0,  enc_i(6'h23, 0, 8, 16'd4));
    load(1'b0, 1,  enc_i(6'h23, 0, 9, 16'd8));
    load(1'b0, 2,  enc_r(9, 8, 10, 6'h20));
    load(1'b0, 3,  enc_i(6'h23, 9, 11, 16'hfff4));
    load(1'b0, 4,  enc_i(6'h2b, 9, 8, 16'hfffc));
    load(1'b0, 5,  enc_r(8, 9, 12, 6'h22));
    load(1'b0, 6,  enc_r(12, 8, 13, 6'h2a));
    load(1'b0, 7,  enc_r(9, 12, 14, 6'h24));
    load(1'b0, 8,  enc_r(8, 9, 15, 6'h25));
    load(1'b0, 9,  enc_r(8, 8, 0, 6'h20));
    load(1'b0, 10, enc_i(6'h04, 8, 11, 16'd3));
    load(1'b0, 11, enc_r(8, 8, 16, 6'h20));
    load(1'b0, 12, enc_r(8, 8, 16, 6'h20));
    load(1'b0, 13, enc_i(6'h04, 8, 9, 16'd5));
    load(1'b0, 14, enc_j(32'h0040_0040));
    load(1'b0, 15, enc_r(8, 8, 17, 6'h20));
    load(1'b0, 16, enc_i(6'h0d, 8, 20, 16'h1234));
    load(1'b0, 17, enc_r(8, 12, 18, 6'h2a));
    load(1'b0, 18, enc_j(32'h0040_0048));
    chk("R1 pc held in reset", pc_o, START);
    rst_ni = 1'b1;
    check_state();
    run_i = 1'b1;
    repeat (30) tick();
    // loads while running must be ignored (R3)
    load(1'b0, 0, enc_i(6'h23, 0, 8, 16'd8));
    load(1'b1, 20, 32'hdead_beef);
    run_i = 1'b0;
    repeat (3) tick();
    chk("R2 pc held while stopped", pc_o, 32'h0040_0048);
    chk("R8 jump target", pc_o, 32'h0040_0048);
    begin
      logic [31:0] exp_r [21] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                  32'h5, 32'h10, 32'h15, 32'h5, 32'hffff_fff5,
                                  32'h1, 32'h10, 32'h15, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
      string tag [21] = '{"R9", "R1", "R1", "R1", "R1", "R1", "R1", "R1",
                          "R5", "R5", "R4 add", "R5 negative offset", "R4 sub",
                          "R4 slt", "R4 and", "R4 or", "R7 taken skip", "R8 skip",
                          "R4 slt false", "R1", "R10 unlisted opcode"};
      for (int i = 0; i < 21; i++) begin
        dbg_reg_addr_i = 5'(i);
        #1;
        chk(tag[i], dbg_reg_data_o, exp_r[i]);
      end
    end
    dbg_mem_addr_i = MEM_AW'(3);
    #1 chk("R6 store", dbg_mem_data_o, 32'h5);
    dbg_mem_addr_i = MEM_AW'(20);
    #1 chk("R3 dmem load ignored while running", dbg_mem_data_o, 32'h1000_0014);
    check_state();
    // instruction memory must still hold the original first word
    @(negedge clk_i);
    assert_reset();
    rst_ni = 1'b1;
    run_i = 1'b1;
    tick();
    run_i = 1'b0;
    dbg_reg_addr_i = 5'd8;
    #1 chk("R3 imem load ignored while running", dbg_reg_data_o, 32'h5);

    // ---------------- random programs ----------------
    for (int r = 0; r < 3; r++) begin
      @(negedge clk_i);
      assert_reset();
      for (int i = 0; i < DEPTH; i++) load(1'b0, i, rnd_ins());
      for (int i = 0; i < DEPTH; i++) load(1'b1, i, $urandom);
      rst_ni = 1'b1;
      for (int c = 0; c < 300; c++) begin
        run_i = ($urandom % 8) != 0;
        if (($urandom % 6) == 0) begin
          ld_we_i = 1'b1;
          ld_sel_i = 1'($urandom % 2);
          ld_addr_i = MEM_AW'($urandom);
          ld_data_i = ld_sel_i ? $urandom : rnd_ins();
        end
        tick();
        ld_we_i = 1'b0;
      end
      run_i = 1'b0;
      check_state();
    end
    finish_test();
  end

endmodule